// File: doc/BRIEF.md
# Graphics command packet framer

This block sits between a stream of 32-bit graphics command words and the drawing engine. Each command starts with an opcode in bits 31:24 of its first word, and that opcode alone sets how many words the command spans. The framer collects the words of one command in a small buffer. Once the command is complete, it forwards it downstream as one packet, one word per cycle, with start and end markers. The drawing engine therefore only ever sees whole commands, even if the producer stalls in the middle of one.

While framing, the block also watches the command stream. It keeps a bank of eight environment registers current, along with a 13-bit status mirror derived from them. It flags every command that changes frame-buffer contents. The two video-memory transfer commands are not forwarded. Their position and size words go to a separate transfer engine, and the word input stays closed until that engine reports it has finished with the stream.

The controller has three states. GATHER accepts words. ISSUE replays a buffered packet. HANDOFF waits for the transfer engine. The transitions are:

- GATHER to ISSUE: a drawing or state command is complete.
- GATHER to HANDOFF: a transfer command is complete.
- ISSUE to GATHER: after the last word of the packet.
- HANDOFF to GATHER: on the cycle after `xfer_done` is seen.

Top module: `cmd_packet_framer`

## Requirements
- R1: During and right after reset, `in_ready` is 1. `pkt_valid`, `pkt_first`, `pkt_last`, `xfer_start` and `frame_dirty` are 0. All environment registers and `status_low` are 0.
- R2: A command spans 1 + N words, where N depends on the opcode (bits 31:24 of word 0):
  - Opcodes 0x20-0x3F, in groups of four starting at 0x20: 3,6,4,8,5,8,7,11.
  - Opcodes 0x40-0x7F, in groups of four starting at 0x40: 2,0,3,3,3,0,4,4,2,3,1,2,1,2,1,2.
  - Opcode 0x02 gives 2, 0x80 gives 3, and 0xA0 and 0xC0 give 2.
  - Every other opcode gives 0.
- R3: A non-transfer packet is emitted only after its final word is accepted. Its words appear in order, one per cycle, from the cycle after that acceptance. `pkt_first` marks word 0 and `pkt_last` marks the final word.
- R4: `in_ready` is 0 while a packet is being emitted and while a transfer is outstanding. A partly received command waits through input gaps of any length.
- R5: An opcode 0xE0-0xE7 command writes its whole word into environment register (opcode & 7), visible the cycle after acceptance. Registers not written keep their values.
- R6: When (opcode & 0xF4) = 0x24, bits 8:0 of environment register 1 take bits 8:0 of packet word 4. When (opcode & 0xF4) = 0x34, they take bits 8:0 of word 5. Bits 31:9 of environment register 1 are unchanged.
- R7: `status_low[10:0]` equals environment register 1 bits 10:0, and `status_low[12:11]` equals environment register 6 bits 1:0.
- R8: Opcodes 0xA0 (write) and 0xC0 (read) are not emitted. Instead, `xfer_start` pulses for one cycle, the cycle after the final word. `xfer_read` is 1 for 0xC0. `xfer_pos` and `xfer_size` carry packet words 1 and 2 and stay valid until the transfer ends.
- R9: Once `xfer_done` is sampled high during a transfer, `in_ready` is 1 on the following cycle.
- R10: `frame_dirty` pulses for one cycle, the cycle after the final word, for every command with opcode from 0x02 up to and including 0xBF. It stays 0 for all other commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Command word offered |
| in_data | input | 32 | Command word |
| in_ready | output | 1 | Word accepted when high together with `in_valid` |
| pkt_valid | output | 1 | Packet word present |
| pkt_data | output | 32 | Packet word |
| pkt_first | output | 1 | First word of the packet |
| pkt_last | output | 1 | Final word of the packet |
| env_regs | output | 8x32 | Environment register bank |
| status_low | output | 13 | Status mirror of environment fields |
| frame_dirty | output | 1 | One-cycle pulse: the command alters the frame buffer |
| xfer_start | output | 1 | One-cycle pulse: a video-memory transfer begins |
| xfer_read | output | 1 | Transfer direction, 1 for read |
| xfer_pos | output | 32 | Transfer position word |
| xfer_size | output | 32 | Transfer size word |
| xfer_done | input | 1 | Transfer engine has finished with the stream |

## Verification
Most results fall due exactly one cycle after the edge that accepts a command's final word. This covers the first packet word, the transfer strobe, the dirty pulse and the environment update. Packet word k follows k cycles after that, and `in_ready` rises one cycle after the final packet word or after `xfer_done` is seen. The bench keeps a queue-based model that advances on the same rising edge as the design. It compares every output on the falling edge that follows, so each expectation is checked in the very cycle it falls due.

// File: rtl/framer_pkg.sv
package framer_pkg;
    localparam int OP_W = 8;

    typedef enum logic [1:0] {
        ST_GATHER,
        ST_ISSUE,
        ST_HANDOFF
    } fr_state_e;

    typedef enum logic [1:0] {
        TP_NONE,
        TP_WORD4,
        TP_WORD5
    } tpage_src_e;

    typedef struct packed {
        logic [3:0] extra;
        logic       dirty;
        logic       is_env;
        logic       is_xfer;
        logic       xfer_rd;
        tpage_src_e tpage;
    } op_info_t;
endpackage

// File: rtl/framer_op_decode.sv
module framer_op_decode
    import framer_pkg::*;
(
    input  logic [OP_W-1:0] op_i,
    output op_info_t        info_o
);
    always_comb begin
        info_o = '0;
        if (op_i[7:5] == 3'b001) begin
            unique case (op_i[4:2])
                3'd0: info_o.extra = 4'd3;
                3'd1: info_o.extra = 4'd6;
                3'd2: info_o.extra = 4'd4;
                3'd3: info_o.extra = 4'd8;
                3'd4: info_o.extra = 4'd5;
                3'd5: info_o.extra = 4'd8;
                3'd6: info_o.extra = 4'd7;
                3'd7: info_o.extra = 4'd11;
            endcase
        end else if (op_i[7:6] == 2'b01) begin
            unique case (op_i[5:2])
                4'd0, 4'd8:                info_o.extra = 4'd2;
                4'd1, 4'd5:                info_o.extra = 4'd0;
                4'd2, 4'd3, 4'd4, 4'd9:    info_o.extra = 4'd3;
                4'd6, 4'd7:                info_o.extra = 4'd4;
                4'd10, 4'd12, 4'd14:       info_o.extra = 4'd1;
                default:                   info_o.extra = 4'd2;
            endcase
        end else begin
            unique case (op_i)
                8'h02, 8'hA0, 8'hC0: info_o.extra = 4'd2;
                8'h80:               info_o.extra = 4'd3;
                default:             info_o.extra = 4'd0;
            endcase
        end
        info_o.dirty   = (op_i >= 8'h02) && (op_i < 8'hC0);
        info_o.is_env  = (op_i[7:3] == 5'b11100);
        info_o.is_xfer = (op_i == 8'hA0) || (op_i == 8'hC0);
        info_o.xfer_rd = (op_i == 8'hC0);
        if ((op_i & 8'hF4) == 8'h24)
            info_o.tpage = TP_WORD4;
        else if ((op_i & 8'hF4) == 8'h34)
            info_o.tpage = TP_WORD5;
    end
endmodule

// File: rtl/framer_env_bank.sv
module framer_env_bank #(
    parameter int DATA_W     = 32,
    parameter int NUM_ENV    = 8,
    parameter int TPAGE_BITS = 9
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           set_en,
    input  logic [$clog2(NUM_ENV)-1:0]     set_idx,
    input  logic [DATA_W-1:0]              set_data,
    input  logic                           tp_en,
    input  logic [TPAGE_BITS-1:0]          tp_bits,
    output logic [NUM_ENV-1:0][DATA_W-1:0] env_q,
    output logic [12:0]                    status_low
);
    localparam int TP_REG   = 1;
    localparam int MASK_REG = 6;
    localparam int MIRROR_W = 11;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            env_q <= '0;
        end else begin
            if (set_en)
                env_q[set_idx] <= set_data;
            if (tp_en)
                env_q[TP_REG][TPAGE_BITS-1:0] <= tp_bits;
        end
    end

    always_comb status_low = {env_q[MASK_REG][1:0], env_q[TP_REG][MIRROR_W-1:0]};

    assert_env_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_en || tp_en) |=> $stable(env_q));
    assert_tpage_upper_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tp_en && !set_en) |=>
            env_q[TP_REG][DATA_W-1:TPAGE_BITS] == $past(env_q[TP_REG][DATA_W-1:TPAGE_BITS]));
endmodule

// File: rtl/cmd_packet_framer.sv
module cmd_packet_framer
    import framer_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int NUM_ENV    = 8,
    parameter int MAX_WORDS  = 12,
    parameter int TPAGE_BITS = 9
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           in_valid,
    input  logic [DATA_W-1:0]              in_data,
    output logic                           in_ready,
    output logic                           pkt_valid,
    output logic [DATA_W-1:0]              pkt_data,
    output logic                           pkt_first,
    output logic                           pkt_last,
    output logic [NUM_ENV-1:0][DATA_W-1:0] env_regs,
    output logic [12:0]                    status_low,
    output logic                           frame_dirty,
    output logic                           xfer_start,
    output logic                           xfer_read,
    output logic [DATA_W-1:0]              xfer_pos,
    output logic [DATA_W-1:0]              xfer_size,
    input  logic                           xfer_done
);
    localparam int IDX_W     = $clog2(MAX_WORDS);
    localparam int BUF_DEPTH = 1 << IDX_W;
    localparam int ENV_IDX_W = $clog2(NUM_ENV);

    fr_state_e         state, state_nxt;
    logic [DATA_W-1:0] pbuf [BUF_DEPTH];
    logic [IDX_W-1:0]  fill, emit_idx, last_idx_q;
    logic [OP_W-1:0]   op_q, dec_op;
    logic              xfer_start_q, xfer_rd_q, dirty_q;
    op_info_t          cur;
    logic              accept, pkt_done;
    logic [DATA_W-1:0] tp_word;

    assign dec_op   = (fill == '0) ? in_data[DATA_W-1 -: OP_W] : op_q;
    assign accept   = in_valid && (state == ST_GATHER);
    assign pkt_done = accept && (fill == IDX_W'(cur.extra));
    assign tp_word  = (cur.tpage == TP_WORD4) ? pbuf[4] : pbuf[5];

    framer_op_decode u_decode (
        .op_i   (dec_op),
        .info_o (cur)
    );

    framer_env_bank #(
        .DATA_W     (DATA_W),
        .NUM_ENV    (NUM_ENV),
        .TPAGE_BITS (TPAGE_BITS)
    ) u_env (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_en     (pkt_done && cur.is_env),
        .set_idx    (dec_op[ENV_IDX_W-1:0]),
        .set_data   (in_data),
        .tp_en      (pkt_done && (cur.tpage != TP_NONE)),
        .tp_bits    (tp_word[TPAGE_BITS-1:0]),
        .env_q      (env_regs),
        .status_low (status_low)
    );

    // Next-state selection
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_GATHER:  if (pkt_done) state_nxt = cur.is_xfer ? ST_HANDOFF : ST_ISSUE;
            ST_ISSUE:   if (emit_idx == last_idx_q) state_nxt = ST_GATHER;
            ST_HANDOFF: if (xfer_done) state_nxt = ST_GATHER;
            default:    state_nxt = ST_GATHER;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_GATHER;
        else        state <= state_nxt;
    end

    // Packet word storage, no reset needed
    always_ff @(posedge clk) begin
        if (accept)
            pbuf[fill] <= in_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill         <= '0;
            op_q         <= '0;
            last_idx_q   <= '0;
            emit_idx     <= '0;
            xfer_start_q <= 1'b0;
            xfer_rd_q    <= 1'b0;
            dirty_q      <= 1'b0;
        end else begin
            xfer_start_q <= 1'b0;
            dirty_q      <= 1'b0;
            if (accept) begin
                if (fill == '0) op_q <= dec_op;
                if (pkt_done) begin
                    fill         <= '0;
                    last_idx_q   <= IDX_W'(cur.extra);
                    dirty_q      <= cur.dirty;
                    xfer_start_q <= cur.is_xfer;
                    xfer_rd_q    <= cur.xfer_rd;
                end else begin
                    fill <= fill + 1'b1;
                end
            end
            emit_idx <= (state == ST_ISSUE) ? emit_idx + 1'b1 : '0;
        end
    end

    // Outputs
    always_comb begin
        in_ready    = (state == ST_GATHER);
        pkt_valid   = (state == ST_ISSUE);
        pkt_data    = pbuf[emit_idx];
        pkt_first   = pkt_valid && (emit_idx == '0);
        pkt_last    = pkt_valid && (emit_idx == last_idx_q);
        frame_dirty = dirty_q;
        xfer_start  = xfer_start_q;
        xfer_read   = xfer_rd_q;
        xfer_pos    = pbuf[1];
        xfer_size   = pbuf[2];
    end

    assert_ready_low_emit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> !in_ready);
    assert_burst_continues_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && !pkt_last) |=> (pkt_valid && !pkt_first));
    assert_burst_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && pkt_last) |=> !pkt_valid);
    assert_xfer_not_emitted_R8: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |-> (!pkt_valid && !in_ready));
    assert_xfer_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> !xfer_start);
    assert_release_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HANDOFF && xfer_done) |=> in_ready);
endmodule

// File: tb/test_cmd_packet_framer.sv
module test_cmd_packet_framer;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cur_valid = 1'b0;
    logic [31:0] cur_data = '0;
    logic xfer_done = 1'b0;

    logic in_ready, pkt_valid, pkt_first, pkt_last, frame_dirty;
    logic xfer_start, xfer_read;
    logic [31:0] pkt_data, xfer_pos, xfer_size;
    logic [7:0][31:0] env_regs;
    logic [12:0] status_low;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmd_packet_framer i_cmd_packet_framer (
        .clk(clk), .rst_n(rst_n), .in_valid(cur_valid), .in_data(cur_data),
        .in_ready(in_ready), .pkt_valid(pkt_valid), .pkt_data(pkt_data),
        .pkt_first(pkt_first), .pkt_last(pkt_last), .env_regs(env_regs),
        .status_low(status_low), .frame_dirty(frame_dirty), .xfer_start(xfer_start),
        .xfer_read(xfer_read), .xfer_pos(xfer_pos), .xfer_size(xfer_size),
        .xfer_done(xfer_done)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    // Reference model state
    logic [32:0] stim_q[$];
    logic [31:0] coll[$];
    logic [31:0] emitq[$];
    logic [31:0] m_env[8];
    int m_state = 0;
    int m_epos = 0;
    int m_xcnt = 0;
    bit m_accepted = 0, m_xstart = 0, m_dirty = 0, m_xread = 0, m_release = 0;
    logic [31:0] m_xpos = '0, m_xsize = '0;

    function automatic int exp_len(logic [7:0] op);
        int e = 0;
        if (op >= 8'h20 && op < 8'h80) begin
            case (op & 8'hFC)
                8'h20: e = 3;  8'h24: e = 6;  8'h28: e = 4;  8'h2C: e = 8;
                8'h30: e = 5;  8'h34: e = 8;  8'h38: e = 7;  8'h3C: e = 11;
                8'h40: e = 2;  8'h44: e = 0;  8'h48: e = 3;  8'h4C: e = 3;
                8'h50: e = 3;  8'h54: e = 0;  8'h58: e = 4;  8'h5C: e = 4;
                8'h60: e = 2;  8'h64: e = 3;  8'h68: e = 1;  8'h6C: e = 2;
                8'h70: e = 1;  8'h74: e = 2;  8'h78: e = 1;  default: e = 2;
            endcase
        end else if (op == 8'h02 || op == 8'hA0 || op == 8'hC0) e = 2;
        else if (op == 8'h80) e = 3;
        return e + 1;
    endfunction

    task automatic finish_packet();
        logic [7:0] op = coll[0][31:24];
        m_dirty = (op >= 8'h02 && op < 8'hC0);
        if (op >= 8'hE0 && op <= 8'hE7) m_env[op & 8'h07] = coll[0];
        if ((op & 8'hF4) == 8'h24) m_env[1][8:0] = coll[4][8:0];
        if ((op & 8'hF4) == 8'h34) m_env[1][8:0] = coll[5][8:0];
        if (op == 8'hA0 || op == 8'hC0) begin
            m_xstart = 1; m_xread = (op == 8'hC0);
            m_xpos = coll[1]; m_xsize = coll[2];
            m_state = 2; m_xcnt = 0;
        end else begin
            emitq = coll; m_epos = 0; m_state = 1;
        end
        coll.delete();
    endtask

    always @(posedge clk) begin
        m_accepted = 0; m_xstart = 0; m_dirty = 0; m_release = 0;
        if (!rst_n) begin
            m_state = 0; coll.delete(); emitq.delete();
            for (int i = 0; i < 8; i++) m_env[i] = '0;
        end else begin
            case (m_state)
                0: if (cur_valid) begin
                    m_accepted = 1;
                    coll.push_back(cur_data);
                    if (coll.size() == exp_len(coll[0][31:24])) finish_packet();
                end
                1: begin
                    void'(emitq.pop_front());
                    m_epos++;
                    if (emitq.size() == 0) m_state = 0;
                end
                default: begin
                    if (xfer_done) begin m_state = 0; m_release = 1; end
                    m_xcnt++;
                end
            endcase
        end
    end

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h at cycle %0d", tag, what, act, exp, cyc);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Compare on falling edge, then drive next inputs
    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            chk("R1", "in_ready", 32'(in_ready), 32'd1);
            chk("R1", "pkt_valid", 32'(pkt_valid), 32'd0);
            chk("R1", "markers", {30'd0, pkt_first, pkt_last}, 32'd0);
            chk("R1", "xfer_start", 32'(xfer_start), 32'd0);
            chk("R1", "frame_dirty", 32'(frame_dirty), 32'd0);
            chk("R1", "status_low", 32'(status_low), 32'd0);
            for (int i = 0; i < 8; i++) chk("R1", "env", env_regs[i], 32'd0);
        end else begin
            chk(m_release ? "R9" : "R4", "in_ready", 32'(in_ready), 32'(m_state == 0));
            chk("R3", "pkt_valid", 32'(pkt_valid), 32'(m_state == 1));
            if (m_state == 1) begin
                chk("R3", "pkt_data", pkt_data, emitq[0]);
                chk("R3", "pkt_first", 32'(pkt_first), 32'(m_epos == 0));
                chk("R2", "pkt_last", 32'(pkt_last), 32'(emitq.size() == 1));
            end else begin
                chk("R3", "markers idle", {30'd0, pkt_first, pkt_last}, 32'd0);
            end
            chk("R8", "xfer_start", 32'(xfer_start), 32'(m_xstart));
            if (m_state == 2) begin
                chk("R8", "xfer_read", 32'(xfer_read), 32'(m_xread));
                chk("R8", "xfer_pos", xfer_pos, m_xpos);
                chk("R8", "xfer_size", xfer_size, m_xsize);
            end
            chk("R10", "frame_dirty", 32'(frame_dirty), 32'(m_dirty));
            for (int i = 0; i < 8; i++) chk(i == 1 ? "R6" : "R5", "env", env_regs[i], m_env[i]);
            chk("R7", "status_low", 32'(status_low), {19'd0, m_env[6][1:0], m_env[1][10:0]});
        end
        // drive
        xfer_done = (m_state == 2 && m_xcnt == 3);
        if (rst_n && (!cur_valid || m_accepted)) begin
            if (stim_q.size() > 0) {cur_valid, cur_data} = stim_q.pop_front();
            else cur_valid = 1'b0;
        end
        if (cyc > WATCHDOG) begin
            n_fail++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            summary();
        end
    end

    task automatic push_pkt(logic [7:0] op, logic [23:0] base, int gap_every);
        int n = exp_len(op);
        for (int i = 0; i < n; i++) begin
            logic [31:0] w = (i == 0) ? {op, base} : (32'h3C00_0000 + {8'd0, base} * 32'd7 + 32'(i * 32'h49));
            stim_q.push_back({1'b1, w});
            if (gap_every > 0 && (i % gap_every) == gap_every - 1)
                for (int g = 0; g < 3; g++) stim_q.push_back(33'd0);
        end
    endtask

    initial begin
        // R5: environment commands, single-word packets
        for (int k = 0; k < 8; k++) push_pkt(8'hE0 + 8'(k), 24'hA50000 + 24'(k * 24'h1111), 0);
        push_pkt(8'hE6, 24'h000002, 0);
        // R6: texture-page snoops, word 4 and word 5 sources
        push_pkt(8'h24, 24'h000101, 0);
        push_pkt(8'h2E, 24'h000202, 2);
        push_pkt(8'h34, 24'h000303, 0);
        push_pkt(8'h37, 24'h000404, 4);
        push_pkt(8'h3C, 24'h000505, 5);
        // R2/R3: every length group of drawing commands, some with stalls
        for (int op = 8'h20; op < 8'h80; op += 4) push_pkt(8'(op + (op % 3)), 24'(op * 3), (op % 12 == 0) ? 1 : 0);
        // R10 and lone opcodes
        push_pkt(8'h02, 24'h000010, 0);
        push_pkt(8'h80, 24'h000020, 2);
        push_pkt(8'h00, 24'h000030, 0);
        push_pkt(8'h01, 24'h000031, 0);
        push_pkt(8'hBF, 24'h000032, 0);
        push_pkt(8'hC1, 24'h000033, 0);
        // R8/R9: transfer commands diverted
        push_pkt(8'hA0, 24'h000040, 0);
        push_pkt(8'h28, 24'h000041, 0);
        push_pkt(8'hC0, 24'h000050, 1);
        push_pkt(8'hE1, 24'hFFFFFF, 0);
        push_pkt(8'h64, 24'h000060, 0);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        wait (stim_q.size() == 0 && !cur_valid && m_state == 0);
        repeat (10) @(negedge clk);
        summary();
    end
endmodule